// File: doc/BRIEF.md
# Coarse Depth/Stencil Quad Rejector

The block keeps a small on-chip summary of the depth and stencil buffers, with one record for each screen tile. Several pixel quads arrive each clock. Each quad names its tile, gives the nearest depth among its pixels, and says whether the stencil test is enabled. The block compares each quad with its tile's record and reports in the next cycle whether the quad can be discarded before shading. Because the record is conservative, a quad that could still be visible is never discarded. The per-pixel depth test downstream remains the final authority.

Each tile record holds 11 bits of coarse depth and one stencil flag. The coarse depth is the farthest depth that any pixel of the tile can hold. The stencil flag marks a tile in which every pixel fails the stencil test. The fine depth stage sends update messages when it changes a tile, and a clear request resets every record. The summary has storage of its own and does not depend on any compressed form of the depth buffer. With the default of four lanes, up to sixteen pixels per clock can be rejected. The lane count is a parameter.

Top module: `hz_early_reject`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), res_vld is all zero. Every tile record then holds the far value (coarse depth 2047, every bit set) with its stencil flag clear, so no quad is rejected until an update arrives.
- R2: Each lane reports one cycle after its quad is presented: res_vld[l] equals the q_vld[l] of the previous cycle, and res_rej[l] is never 1 while res_vld[l] is 0.
- R3: A valid quad is rejected on depth when the upper 11 bits of its q_zmin (bits 15:5) are strictly greater than its tile's coarse depth. When the two are equal, the quad passes.
- R4: A valid quad with q_sten set is rejected when its tile's stencil flag is set. With q_sten clear, the stencil flag has no effect on the result.
- R5: A full-coverage update (upd_vld and upd_full) quantizes upd_zmax by keeping bits 15:5. It stores that value only when it is below the current coarse depth, so an update never raises the stored depth.
- R6: A partial update (upd_vld with upd_full low) leaves the tile's coarse depth unchanged and clears the tile's stencil flag.
- R7: A full-coverage update sets the tile's stencil flag to upd_sfail.
- R8: A clear resets every tile to the far value with its stencil flag clear. If an update arrives in the same cycle as a clear, the update is discarded.
- R9: A quad presented in the same cycle as an update or clear of its tile is judged against the record as it stands after that write.
- R10: Lanes are independent. Each lane uses the record at tile index q_ty*8+q_tx, and a write to one tile changes the results for no other tile.
- R11: A valid quad with q_zmin equal to 0 and q_sten clear is never rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Reset every tile record to far |
| upd_vld | input | 1 | Tile update message valid |
| upd_tx | input | 3 | Update tile column |
| upd_ty | input | 3 | Update tile row |
| upd_zmax | input | 16 | Farthest fine depth now in the tile |
| upd_full | input | 1 | Update covers the whole tile |
| upd_sfail | input | 1 | Every pixel of the tile now fails stencil |
| q_vld | input | 4 | Per-lane quad valid |
| q_tx | input | 12 | Per-lane tile column, 3 bits per lane |
| q_ty | input | 12 | Per-lane tile row, 3 bits per lane |
| q_zmin | input | 64 | Per-lane nearest quad depth, 16 bits per lane |
| q_sten | input | 4 | Per-lane stencil test enable |
| res_vld | output | 4 | Per-lane result valid |
| res_rej | output | 4 | Per-lane reject decision |

## Verification
The hardest case to reach is a collision inside a single cycle. Here a quad's tile is written in the same cycle that the quad is tested, or a clear arrives together with an update. Ordinary traffic almost never lines these up. Directed steps therefore present an update together with a quad to the same tile, and a clear together with an update. A random phase then confines tile coordinates to a 4x4 corner of the grid, so that writes and tests often meet on one tile, including across different lanes. The behavioural model in the bench applies writes before tests and is compared with every lane on every clock.

// File: rtl/hz_pkg.sv
// Shared types for the coarse depth/stencil rejector.
// Assumes: a single write action per cycle is applied to the tile store.
package hz_pkg;
    typedef enum logic [1:0] {
        HZ_WR_NONE  = 2'd0,
        HZ_WR_CLEAR = 2'd1,
        HZ_WR_FULL  = 2'd2,
        HZ_WR_PART  = 2'd3
    } hz_wr_e;
endpackage

// File: rtl/hz_wr_ctrl.sv
// Decodes clear/update inputs into one tile-store write action.
// Assumes: clear outranks update; quantization keeps the upper CZW bits,
// which (expanded with ones below) is never nearer than the fine depth.
module hz_wr_ctrl
    import hz_pkg::*;
#(
    parameter int TILES_X = 8,
    parameter int TXW     = 3,
    parameter int TYW     = 3,
    parameter int TIW     = 6,
    parameter int FZW     = 16,
    parameter int CZW     = 11
) (
    input  logic           clr,
    input  logic           upd_vld,
    input  logic [TXW-1:0] upd_tx,
    input  logic [TYW-1:0] upd_ty,
    input  logic [FZW-1:0] upd_zmax,
    input  logic           upd_full,
    output hz_wr_e         act,
    output logic [TIW-1:0] wr_idx,
    output logic [CZW-1:0] wr_cz
);
    // Select the write action with clear first.
    always_comb begin
        if (clr)           act = HZ_WR_CLEAR;
        else if (!upd_vld) act = HZ_WR_NONE;
        else if (upd_full) act = HZ_WR_FULL;
        else               act = HZ_WR_PART;
    end

    // Row-major tile index and conservative coarse depth.
    assign wr_idx = TIW'(upd_ty) * TIW'(TILES_X) + TIW'(upd_tx);
    assign wr_cz  = upd_zmax[FZW-1 -: CZW];
endmodule

// File: rtl/hz_tile_store.sv
// Register array of per-tile coarse records (depth + stencil-fail flag).
// Exposes the post-write state so same-cycle tests see the write first.
// Assumes: wr_idx is below NT.
module hz_tile_store
    import hz_pkg::*;
#(
    parameter int NT  = 64,
    parameter int TIW = 6,
    parameter int CZW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hz_wr_e            act,
    input  logic [TIW-1:0]    wr_idx,
    input  logic [CZW-1:0]    wr_cz,
    input  logic              wr_sfail,
    output logic [NT*CZW-1:0] nxt_depth,
    output logic [NT-1:0]     nxt_sten
);
    for (genvar t = 0; t < NT; t++) begin : g_tile
        logic [CZW-1:0] cur_d;
        logic           cur_s;
        logic [CZW-1:0] new_d;
        logic           new_s;
        logic           hit;

        assign hit = (wr_idx == TIW'(t));

        // Next record: clear, lower-only full write, or partial write.
        always_comb begin
            new_d = cur_d;
            new_s = cur_s;
            case (act)
                HZ_WR_CLEAR: begin
                    new_d = '1;
                    new_s = 1'b0;
                end
                HZ_WR_FULL: if (hit) begin
                    new_d = (wr_cz < cur_d) ? wr_cz : cur_d;
                    new_s = wr_sfail;
                end
                HZ_WR_PART: if (hit) new_s = 1'b0;
                default: ;
            endcase
        end

        // Hold the record; reset to far with the flag clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_d <= '1;
                cur_s <= 1'b0;
            end else begin
                cur_d <= new_d;
                cur_s <= new_s;
            end
        end

        assign nxt_depth[t*CZW +: CZW] = new_d;
        assign nxt_sten[t]             = new_s;
    end
endmodule

// File: rtl/hz_quad_test.sv
// One lane: looks up the quad's tile record and decides rejection.
// Assumes: tile coordinates are in range; rejects only on certain failure.
module hz_quad_test #(
    parameter int NT      = 64,
    parameter int TILES_X = 8,
    parameter int TXW     = 3,
    parameter int TYW     = 3,
    parameter int TIW     = 6,
    parameter int FZW     = 16,
    parameter int CZW     = 11
) (
    input  logic              vld,
    input  logic [TXW-1:0]    tx,
    input  logic [TYW-1:0]    ty,
    input  logic [FZW-1:0]    zmin,
    input  logic              sten,
    input  logic [NT*CZW-1:0] tile_depth,
    input  logic [NT-1:0]     tile_sten,
    output logic              rej
);
    logic [TIW-1:0] idx;
    logic [CZW-1:0] far_cz;
    logic           z_fail;
    logic           s_fail;

    // Row-major index of the quad's tile.
    assign idx    = TIW'(ty) * TIW'(TILES_X) + TIW'(tx);
    assign far_cz = tile_depth[idx*CZW +: CZW];

    // Nearest quad depth beyond the tile's farthest bound, or stencil fail.
    assign z_fail = zmin[FZW-1 -: CZW] > far_cz;
    assign s_fail = sten & tile_sten[idx];
    assign rej    = vld & (z_fail | s_fail);
endmodule

// File: rtl/hz_early_reject.sv
// Top: coarse per-tile depth/stencil summary with LANES quad testers.
// Results are registered one cycle after the quads are presented.
// Assumes: at most one update per cycle; tile coordinates within the grid.
module hz_early_reject
    import hz_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int TILES_X = 8,
    parameter int TILES_Y = 8,
    parameter int FZW     = 16,
    parameter int CZW     = 11,
    localparam int TXW    = $clog2(TILES_X),
    localparam int TYW    = $clog2(TILES_Y),
    localparam int NT     = TILES_X * TILES_Y,
    localparam int TIW    = $clog2(NT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 upd_vld,
    input  logic [TXW-1:0]       upd_tx,
    input  logic [TYW-1:0]       upd_ty,
    input  logic [FZW-1:0]       upd_zmax,
    input  logic                 upd_full,
    input  logic                 upd_sfail,
    input  logic [LANES-1:0]     q_vld,
    input  logic [LANES*TXW-1:0] q_tx,
    input  logic [LANES*TYW-1:0] q_ty,
    input  logic [LANES*FZW-1:0] q_zmin,
    input  logic [LANES-1:0]     q_sten,
    output logic [LANES-1:0]     res_vld,
    output logic [LANES-1:0]     res_rej
);
    hz_wr_e            act;
    logic [TIW-1:0]    wr_idx;
    logic [CZW-1:0]    wr_cz;
    logic [NT*CZW-1:0] nxt_depth;
    logic [NT-1:0]     nxt_sten;
    logic [LANES-1:0]  lane_rej;

    hz_wr_ctrl #(
        .TILES_X(TILES_X), .TXW(TXW), .TYW(TYW), .TIW(TIW),
        .FZW(FZW), .CZW(CZW)
    ) wr_ctrl_i (
        .clr(clr), .upd_vld(upd_vld), .upd_tx(upd_tx), .upd_ty(upd_ty),
        .upd_zmax(upd_zmax), .upd_full(upd_full),
        .act(act), .wr_idx(wr_idx), .wr_cz(wr_cz)
    );

    hz_tile_store #(.NT(NT), .TIW(TIW), .CZW(CZW)) store_i (
        .clk(clk), .rst_n(rst_n), .act(act), .wr_idx(wr_idx),
        .wr_cz(wr_cz), .wr_sfail(upd_sfail),
        .nxt_depth(nxt_depth), .nxt_sten(nxt_sten)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        hz_quad_test #(
            .NT(NT), .TILES_X(TILES_X), .TXW(TXW), .TYW(TYW), .TIW(TIW),
            .FZW(FZW), .CZW(CZW)
        ) test_i (
            .vld(q_vld[l]),
            .tx(q_tx[l*TXW +: TXW]),
            .ty(q_ty[l*TYW +: TYW]),
            .zmin(q_zmin[l*FZW +: FZW]),
            .sten(q_sten[l]),
            .tile_depth(nxt_depth),
            .tile_sten(nxt_sten),
            .rej(lane_rej[l])
        );
    end

    // Register per-lane results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= '0;
            res_rej <= '0;
        end else begin
            res_vld <= q_vld;
            res_rej <= lane_rej;
        end
    end
endmodule

// File: rtl/hz_early_reject_chk.sv
// Port-level properties of the rejector, bound to every instance.
module hz_early_reject_chk #(
    parameter int LANES = 4,
    parameter int FZW   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic [LANES-1:0]     q_vld,
    input logic [LANES*FZW-1:0] q_zmin,
    input logic [LANES-1:0]     q_sten,
    input logic [LANES-1:0]     res_vld,
    input logic [LANES-1:0]     res_rej
);
    // R1
    rst_idle_chk: assert property (@(posedge clk) !rst_n |=> (res_vld == '0));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (res_vld == $past(q_vld)));

    // R2
    rej_only_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_rej & ~res_vld) == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R8
        clr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && q_vld[l] && !q_sten[l]) |=> !res_rej[l]);

        // R11
        near_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_vld[l] && !q_sten[l] && (q_zmin[l*FZW +: FZW] == '0)) |=> !res_rej[l]);
    end
endmodule

bind hz_early_reject hz_early_reject_chk #(.LANES(LANES), .FZW(FZW)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .q_vld(q_vld), .q_zmin(q_zmin),
    .q_sten(q_sten), .res_vld(res_vld), .res_rej(res_rej)
);

// File: tb/hz_early_reject_tb_top.sv
// Bench: behavioural tile model stepped at each falling edge and compared
// with every lane's registered result.
module hz_early_reject_tb_top;
    localparam int L  = 4;
    localparam int NT = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, clr, upd_vld, upd_full, upd_sfail;
    logic [2:0]  upd_tx, upd_ty;
    logic [15:0] upd_zmax;
    logic [L-1:0]    q_vld, q_sten, res_vld, res_rej;
    logic [L*3-1:0]  q_tx, q_ty;
    logic [L*16-1:0] q_zmin;

    // Stimulus variables set by the sequence, applied at falling edges.
    logic        b_rst, b_clr, b_uv, b_uf, b_us;
    logic [2:0]  b_utx, b_uty;
    logic [15:0] b_uz;
    logic        lv[L], ls[L];
    logic [2:0]  ltx[L], lty[L];
    logic [15:0] lz[L];

    int   mz[NT];
    bit   ms[NT];
    logic exp_vld[L], exp_rej[L];
    bit   chk_on = 1'b0;
    string ptag = "";
    int   tests = 0, fails = 0;

    hz_early_reject dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd_vld(upd_vld),
        .upd_tx(upd_tx), .upd_ty(upd_ty), .upd_zmax(upd_zmax),
        .upd_full(upd_full), .upd_sfail(upd_sfail),
        .q_vld(q_vld), .q_tx(q_tx), .q_ty(q_ty), .q_zmin(q_zmin),
        .q_sten(q_sten), .res_vld(res_vld), .res_rej(res_rej)
    );

    task automatic idle();
        b_clr = 1'b0; b_uv = 1'b0; b_uf = 1'b0; b_us = 1'b0;
        b_utx = '0; b_uty = '0; b_uz = '0;
        for (int l = 0; l < L; l++) begin
            lv[l] = 1'b0; ls[l] = 1'b0; ltx[l] = '0; lty[l] = '0; lz[l] = '0;
        end
    endtask

    task automatic lane(input int l, input int tx, input int ty,
                        input logic [15:0] z, input logic s);
        lv[l] = 1'b1; ltx[l] = 3'(tx); lty[l] = 3'(ty); lz[l] = z; ls[l] = s;
    endtask

    task automatic upd(input int tx, input int ty, input logic [15:0] z,
                       input logic full, input logic sf);
        b_uv = 1'b1; b_utx = 3'(tx); b_uty = 3'(ty); b_uz = z;
        b_uf = full; b_us = sf;
    endtask

    // Check previous results, drive new inputs, advance the model.
    task automatic step(input string tag);
        int idx;
        @(negedge clk);
        if (chk_on) begin
            for (int l = 0; l < L; l++) begin
                tests++;
                if (res_vld[l] !== exp_vld[l] || res_rej[l] !== exp_rej[l]) begin
                    fails++;
                    $display("FAIL %s lane %0d: vld/rej actual %b/%b expected %b/%b",
                             ptag, l, res_vld[l], res_rej[l], exp_vld[l], exp_rej[l]);
                end
            end
        end
        rst_n = b_rst; clr = b_clr; upd_vld = b_uv; upd_tx = b_utx;
        upd_ty = b_uty; upd_zmax = b_uz; upd_full = b_uf; upd_sfail = b_us;
        for (int l = 0; l < L; l++) begin
            q_vld[l] = lv[l]; q_sten[l] = ls[l];
            q_tx[l*3 +: 3] = ltx[l]; q_ty[l*3 +: 3] = lty[l];
            q_zmin[l*16 +: 16] = lz[l];
        end
        if (!b_rst || b_clr) begin
            for (int t = 0; t < NT; t++) begin mz[t] = 2047; ms[t] = 1'b0; end
        end else if (b_uv) begin
            idx = int'(b_uty) * 8 + int'(b_utx);
            if (b_uf) begin
                if (int'(b_uz >> 5) < mz[idx]) mz[idx] = int'(b_uz >> 5);
                ms[idx] = b_us;
            end else ms[idx] = 1'b0;
        end
        for (int l = 0; l < L; l++) begin
            idx = int'(lty[l]) * 8 + int'(ltx[l]);
            exp_vld[l] = b_rst & lv[l];
            exp_rej[l] = b_rst & lv[l] &
                         ((int'(lz[l] >> 5) > mz[idx]) || (ls[l] && ms[idx]));
        end
        ptag = tag;
        chk_on = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(); b_rst = 1'b0;
        step("R1"); step("R1"); step("R1");
        // R1: every tile far and stencil clear after reset
        b_rst = 1'b1;
        lane(0, 0, 0, 16'hFFFF, 1'b1); lane(1, 7, 7, 16'hFFFF, 1'b1);
        lane(2, 3, 5, 16'hFFE0, 1'b1); lane(3, 6, 1, 16'hFFFF, 1'b1);
        step("R1");
        // R5: full update, then R3 strict compare and R10 lane/tile isolation
        idle(); upd(1, 2, 16'h1234, 1'b1, 1'b0); step("R5");
        idle();
        lane(0, 1, 2, 16'h1240, 1'b0); lane(1, 1, 2, 16'h123F, 1'b0);
        lane(2, 2, 1, 16'h1240, 1'b0);
        step("R3 R10");
        // R5: a farther full update does not raise the bound
        idle(); upd(1, 2, 16'h8000, 1'b1, 1'b0); step("R5");
        idle(); lane(0, 1, 2, 16'h1240, 1'b0); lane(3, 1, 2, 16'h0100, 1'b1);
        step("R5");
        // R7: full update sets stencil flag; R4 and R11 with stencil off
        idle(); upd(3, 3, 16'hFFFF, 1'b1, 1'b1); step("R7");
        idle(); lane(0, 3, 3, 16'h0000, 1'b1); lane(1, 3, 3, 16'h0000, 1'b0);
        step("R4 R7 R11");
        // R6: partial update clears stencil and keeps depth
        idle(); upd(3, 3, 16'h0000, 1'b0, 1'b1); step("R6");
        idle(); lane(0, 3, 3, 16'hFFFF, 1'b1); step("R6");
        idle(); upd(1, 2, 16'h0000, 1'b0, 1'b0); lane(1, 1, 2, 16'h1240, 1'b0);
        step("R6 R9");
        // R9: same-cycle update of the tested tile
        idle(); upd(5, 6, 16'h0400, 1'b1, 1'b0);
        lane(0, 5, 6, 16'h0800, 1'b0); lane(1, 5, 6, 16'h041F, 1'b0);
        step("R9");
        // R8: clear with a same-cycle update, update discarded
        idle(); b_clr = 1'b1; upd(5, 6, 16'h0000, 1'b1, 1'b1);
        lane(0, 1, 2, 16'hFFFF, 1'b1); lane(1, 5, 6, 16'hFFFF, 1'b1);
        step("R8");
        idle(); lane(0, 5, 6, 16'hFFFF, 1'b1); lane(2, 1, 2, 16'hFFFF, 1'b0);
        step("R8");
        // R2 R10: random traffic concentrated on a 4x4 corner
        for (int c = 0; c < 400; c++) begin
            idle();
            b_clr = ($urandom_range(0, 59) == 0);
            if ($urandom_range(0, 2) == 0)
                upd($urandom_range(0, 3), $urandom_range(0, 3),
                    16'($urandom_range(0, 65535)), 1'($urandom_range(0, 3) != 0),
                    1'($urandom_range(0, 1)));
            for (int l = 0; l < L; l++)
                if ($urandom_range(0, 3) != 0)
                    lane(l, $urandom_range(0, 3), $urandom_range(0, 3),
                         16'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)));
            step("R2 R10");
        end
        idle(); step("R2");
        idle(); step("R2");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule